// File: doc/BRIEF.md
# Paged Call Target Translation Table

This block sits in the instruction fetch path of a stack processor. Each subroutine call destination is used as an index into a small binding RAM, and the word stored there becomes the next program counter. The call therefore lands on whatever routine is currently bound to that token. The lookup is a single registered stage that runs alongside instruction decode. Translated calls take the same number of cycles as plain fetches.

The RAM is split into pages, one page per task. A page-select register chooses which page the fetch side reads. One write to that register swaps the entire binding environment of the outgoing task for that of the incoming one.

A software port can read or write any slot on any page. Software can fetch an old binding before it replaces it. Each slot has a bound flag that reset clears. A call to a slot that was never written keeps its own destination. Call destinations at or above the number of token slots are never translated.

Top module: `call_xlate_table`

## Requirements
- R1: After reset, pc_valid_o and sw_rvalid_o are 0 and active_page_o is 0. Every slot on every page reads back with sw_rbound_o = 0.
- R2: A fetch presented with fetch_i = 1 yields pc_valid_o = 1 and next_pc_o exactly one cycle later, for calls and non-calls alike. A cycle with fetch_i = 0 gives pc_valid_o = 0 in the following cycle.
- R3: A fetch with call_i = 0 returns dest_i unchanged on next_pc_o, with xlated_o = 0.
- R4: A call whose dest_i is below SLOTS, where slot dest_i is bound on the active page, returns the stored word on next_pc_o with xlated_o = 1.
- R5: A call whose dest_i is at or above SLOTS returns dest_i unchanged, with xlated_o = 0.
- R6: A call to an in-range slot that is not bound on the active page returns dest_i unchanged, with xlated_o = 0.
- R7: A software write (sw_req_i = 1, sw_we_i = 1) stores sw_wdata_i in slot sw_slot_i of page sw_page_i and marks that slot bound. No other page is affected.
- R8: A software read (sw_req_i = 1, sw_we_i = 0) presents the slot's word and bound flag on sw_rdata_o and sw_rbound_o one cycle later, with sw_rvalid_o = 1.
- R9: A write to the page-select register (page_we_i = 1) changes active_page_o at the next cycle. A call presented in the same cycle as that write is translated through the old page.
- R10: When a software write and a call lookup hit the same slot in the same cycle, the call returns the old contents. The new binding applies to calls presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_i | input | 1 | A fetch address is presented this cycle |
| call_i | input | 1 | The presented address is a subroutine call destination |
| dest_i | input | ADDR_W | Call destination or sequential fetch address |
| pc_valid_o | output | 1 | next_pc_o holds a result |
| next_pc_o | output | ADDR_W | Next program counter |
| xlated_o | output | 1 | next_pc_o came from the binding table |
| sw_req_i | input | 1 | Software access request |
| sw_we_i | input | 1 | 1 = write binding, 0 = read binding |
| sw_page_i | input | $clog2(PAGES) | Page for the software access |
| sw_slot_i | input | $clog2(SLOTS) | Token slot for the software access |
| sw_wdata_i | input | ADDR_W | New binding |
| sw_rvalid_o | output | 1 | Read result valid |
| sw_rdata_o | output | ADDR_W | Binding read back |
| sw_rbound_o | output | 1 | Slot read back is bound |
| page_we_i | input | 1 | Load page-select register |
| page_i | input | $clog2(PAGES) | New active page |
| active_page_o | output | $clog2(PAGES) | Page used by fetch lookups |

## Verification
The pass-through properties compare next_pc_o against the dest_i seen one cycle earlier. They assume the fetch inputs are held at 0 while reset is asserted, so the first post-reset comparison is against defined values. The properties also assume SLOTS is a power of two below 2**ADDR_W, so the token range is a simple prefix check. The bench holds every input at 0 through reset and changes inputs only well after a clock edge. It uses a 16-slot, 4-page, 10-bit configuration, in which every slot of every page is swept and out-of-range destinations sit above slot 15.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    FK_IDLE   = 2'd0,
    FK_PASS   = 2'd1,
    FK_LOOKUP = 2'd2
  } fetch_kind_e;
endpackage

// File: rtl/page_select_reg.sv
module page_select_reg #(
  parameter int PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= '0;
    else if (we_i) page_q <= page_i;
  end

  assign page_o = page_q;

  AST_PAGE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> page_o == $past(page_i)); // R9
  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(page_o)); // R9
endmodule

// File: rtl/binding_store.sv
module binding_store #(
  parameter int ADDR_W = 15,
  parameter int PAGES  = 8,
  parameter int SLOTS  = 256,
  localparam int PAGE_W  = $clog2(PAGES),
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int ENTRIES = PAGES * SLOTS,
  localparam int IDX_W   = PAGE_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // fetch lookup port
  input  logic              lk_re_i,
  input  logic [PAGE_W-1:0] lk_page_i,
  input  logic [SLOT_W-1:0] lk_slot_i,
  output logic [ADDR_W-1:0] lk_data_o,
  output logic              lk_bound_o,
  // software port
  input  logic              sw_req_i,
  input  logic              sw_we_i,
  input  logic [PAGE_W-1:0] sw_page_i,
  input  logic [SLOT_W-1:0] sw_slot_i,
  input  logic [ADDR_W-1:0] sw_wdata_i,
  output logic              sw_rvalid_o,
  output logic [ADDR_W-1:0] sw_rdata_o,
  output logic              sw_rbound_o
);
  logic [ADDR_W-1:0]  mem_q [ENTRIES];
  logic [ENTRIES-1:0] bound_q;
  logic [ADDR_W-1:0]  lk_data_q, sw_rdata_q;
  logic               lk_bound_q, sw_rbound_q, sw_rvalid_q;
  logic [IDX_W-1:0]   lk_idx, sw_idx;
  logic               sw_wr, sw_rd;

  assign lk_idx = {lk_page_i, lk_slot_i};
  assign sw_idx = {sw_page_i, sw_slot_i};
  assign sw_wr  = sw_req_i & sw_we_i;
  assign sw_rd  = sw_req_i & ~sw_we_i;

  // read-first: same-cycle lookups see the old word
  always_ff @(posedge clk_i) begin
    if (sw_wr)   mem_q[sw_idx] <= sw_wdata_i;
    if (lk_re_i) lk_data_q     <= mem_q[lk_idx];
    if (sw_rd)   sw_rdata_q    <= mem_q[sw_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bound_q     <= '0;
      lk_bound_q  <= 1'b0;
      sw_rbound_q <= 1'b0;
      sw_rvalid_q <= 1'b0;
    end else begin
      if (sw_wr)   bound_q[sw_idx] <= 1'b1;
      if (lk_re_i) lk_bound_q      <= bound_q[lk_idx];
      if (sw_rd)   sw_rbound_q     <= bound_q[sw_idx];
      sw_rvalid_q <= sw_rd;
    end
  end

  assign lk_data_o   = lk_data_q;
  assign lk_bound_o  = lk_bound_q;
  assign sw_rdata_o  = sw_rdata_q;
  assign sw_rbound_o = sw_rbound_q;
  assign sw_rvalid_o = sw_rvalid_q;

  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rd |=> sw_rvalid_o); // R8
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_rd |=> !sw_rvalid_o); // R8
endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int SLOTS  = 256,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] dest_i,
  output logic              lk_re_o,
  output logic [SLOT_W-1:0] lk_slot_o,
  input  logic [ADDR_W-1:0] lk_data_i,
  input  logic              lk_bound_i,
  output logic              pc_valid_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              xlated_o
);
  fetch_kind_e       kind_d, kind_q;
  logic [ADDR_W-1:0] dest_q;
  logic              in_range, hit;

  assign in_range  = (dest_i[ADDR_W-1:SLOT_W] == '0);
  assign lk_re_o   = fetch_i & call_i & in_range;
  assign lk_slot_o = dest_i[SLOT_W-1:0];

  always_comb begin
    kind_d = FK_IDLE;
    if (fetch_i) kind_d = lk_re_o ? FK_LOOKUP : FK_PASS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= FK_IDLE;
      dest_q <= '0;
    end else begin
      kind_q <= kind_d;
      if (fetch_i) dest_q <= dest_i;
    end
  end

  assign hit        = (kind_q == FK_LOOKUP) & lk_bound_i;
  assign pc_valid_o = (kind_q != FK_IDLE);
  assign xlated_o   = hit;
  assign next_pc_o  = hit ? lk_data_i : dest_q;

  AST_FETCH_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |=> pc_valid_o); // R2
  AST_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_i |=> !pc_valid_o); // R2
  AST_SEQ_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && !call_i) |=> (next_pc_o == $past(dest_i)) && !xlated_o); // R3
  AST_FAR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && call_i && dest_i >= ADDR_W'(SLOTS)) |=> (next_pc_o == $past(dest_i)) && !xlated_o); // R5
  AST_XLATE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlated_o |-> pc_valid_o); // R4
endmodule

// File: rtl/call_xlate_table.sv
module call_xlate_table #(
  parameter int ADDR_W = 15,
  parameter int PAGES  = 8,
  parameter int SLOTS  = 256,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] dest_i,
  output logic              pc_valid_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              xlated_o,
  input  logic              sw_req_i,
  input  logic              sw_we_i,
  input  logic [PAGE_W-1:0] sw_page_i,
  input  logic [SLOT_W-1:0] sw_slot_i,
  input  logic [ADDR_W-1:0] sw_wdata_i,
  output logic              sw_rvalid_o,
  output logic [ADDR_W-1:0] sw_rdata_o,
  output logic              sw_rbound_o,
  input  logic              page_we_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PAGE_W-1:0] active_page_o
);
  logic              lk_re, lk_bound;
  logic [SLOT_W-1:0] lk_slot;
  logic [ADDR_W-1:0] lk_data;

  page_select_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (page_we_i),
    .page_i (page_i),
    .page_o (active_page_o)
  );

  fetch_stage #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_i    (fetch_i),
    .call_i     (call_i),
    .dest_i     (dest_i),
    .lk_re_o    (lk_re),
    .lk_slot_o  (lk_slot),
    .lk_data_i  (lk_data),
    .lk_bound_i (lk_bound),
    .pc_valid_o (pc_valid_o),
    .next_pc_o  (next_pc_o),
    .xlated_o   (xlated_o)
  );

  // lookup uses the page held in the register during the request cycle
  binding_store #(.ADDR_W(ADDR_W), .PAGES(PAGES), .SLOTS(SLOTS)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_re_i     (lk_re),
    .lk_page_i   (active_page_o),
    .lk_slot_i   (lk_slot),
    .lk_data_o   (lk_data),
    .lk_bound_o  (lk_bound),
    .sw_req_i    (sw_req_i),
    .sw_we_i     (sw_we_i),
    .sw_page_i   (sw_page_i),
    .sw_slot_i   (sw_slot_i),
    .sw_wdata_i  (sw_wdata_i),
    .sw_rvalid_o (sw_rvalid_o),
    .sw_rdata_o  (sw_rdata_o),
    .sw_rbound_o (sw_rbound_o)
  );

  AST_RST_PAGE: assert property (@(posedge clk_i)
    !rst_ni |=> (active_page_o == '0) || rst_ni); // R1
endmodule

// File: tb/call_xlate_table_bench.sv
module call_xlate_table_bench;
  localparam int AW = 10;
  localparam int NP = 4;
  localparam int NS = 16;
  localparam int PW = $clog2(NP);
  localparam int SW = $clog2(NS);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fetch_i = 1'b0, call_i = 1'b0;
  logic [AW-1:0] dest_i = '0;
  logic          pc_valid_o, xlated_o;
  logic [AW-1:0] next_pc_o;
  logic          sw_req_i = 1'b0, sw_we_i = 1'b0;
  logic [PW-1:0] sw_page_i = '0;
  logic [SW-1:0] sw_slot_i = '0;
  logic [AW-1:0] sw_wdata_i = '0;
  logic          sw_rvalid_o, sw_rbound_o;
  logic [AW-1:0] sw_rdata_o;
  logic          page_we_i = 1'b0;
  logic [PW-1:0] page_i = '0;
  logic [PW-1:0] active_page_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  call_xlate_table #(.ADDR_W(AW), .PAGES(NP), .SLOTS(NS)) u_call_xlate_table (.*);

  function automatic int bval(int p, int s);
    return (p * 97 + s * 13 + 600) % 1024;
  endfunction
  function automatic bit is_bound(int s);
    return (s % 5) != 3;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    fetch_i = 0; call_i = 0; dest_i = '0;
    sw_req_i = 0; sw_we_i = 0; page_we_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic do_fetch(bit c, int d);
    idle(); fetch_i = 1; call_i = c; dest_i = AW'(d);
    tick();
  endtask

  task automatic sw_write(int p, int s, int v);
    idle(); sw_req_i = 1; sw_we_i = 1;
    sw_page_i = PW'(p); sw_slot_i = SW'(s); sw_wdata_i = AW'(v);
    tick();
  endtask

  task automatic sw_read(int p, int s);
    idle(); sw_req_i = 1; sw_page_i = PW'(p); sw_slot_i = SW'(s);
    tick();
  endtask

  task automatic set_page(int p);
    idle(); page_we_i = 1; page_i = PW'(p);
    tick();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    check("R1 pc_valid", int'(pc_valid_o), 0);
    check("R1 sw_rvalid", int'(sw_rvalid_o), 0);
    check("R1 page", int'(active_page_o), 0);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++) begin
        sw_read(p, s);
        check("R1 unbound", int'(sw_rbound_o), 0);
        check("R8 rvalid", int'(sw_rvalid_o), 1);
      end
    // R6 calls before any binding
    for (int s = 0; s < NS; s++) begin
      do_fetch(1, s);
      check("R6 pc", int'(next_pc_o), s);
      check("R6 xlated", int'(xlated_o), 0);
    end
    // R7 bind all pages, skip some slots
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++)
        if (is_bound(s)) sw_write(p, s, bval(p, s));
    // R8 read back
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++) begin
        sw_read(p, s);
        check("R8 rbound", int'(sw_rbound_o), int'(is_bound(s)));
        if (is_bound(s)) check("R8 rdata", int'(sw_rdata_o), bval(p, s));
      end
    // R4/R6/R3/R5/R2 sweep per page
    for (int p = 0; p < NP; p++) begin
      set_page(p);
      check("R9 page", int'(active_page_o), p);
      for (int s = 0; s < NS; s++) begin
        do_fetch(1, s);
        check("R2 valid", int'(pc_valid_o), 1);
        check("R4 pc", int'(next_pc_o), is_bound(s) ? bval(p, s) : s);
        check("R4 xlated", int'(xlated_o), int'(is_bound(s)));
        do_fetch(0, s);
        check("R3 pc", int'(next_pc_o), s);
        check("R3 xlated", int'(xlated_o), 0);
        do_fetch(1, NS + s * 37 + p);
        check("R5 pc", int'(next_pc_o), NS + s * 37 + p);
        check("R5 xlated", int'(xlated_o), 0);
      end
    end
    idle(); tick();
    check("R2 idle", int'(pc_valid_o), 0);
    // R9 page write and call in the same cycle
    set_page(0);
    idle(); page_we_i = 1; page_i = PW'(2); fetch_i = 1; call_i = 1; dest_i = AW'(1);
    tick();
    check("R9 old page", int'(next_pc_o), bval(0, 1));
    check("R9 page now", int'(active_page_o), 2);
    do_fetch(1, 1);
    check("R9 new page", int'(next_pc_o), bval(2, 1));
    // R10 same-slot write and call
    idle(); fetch_i = 1; call_i = 1; dest_i = AW'(2);
    sw_req_i = 1; sw_we_i = 1; sw_page_i = PW'(2); sw_slot_i = SW'(2); sw_wdata_i = AW'(777);
    tick();
    check("R10 old", int'(next_pc_o), bval(2, 2));
    do_fetch(1, 2);
    check("R10 new", int'(next_pc_o), 777);
    // R10 on a previously unbound slot
    idle(); fetch_i = 1; call_i = 1; dest_i = AW'(3);
    sw_req_i = 1; sw_we_i = 1; sw_page_i = PW'(2); sw_slot_i = SW'(3); sw_wdata_i = AW'(555);
    tick();
    check("R10 unbound old", int'(next_pc_o), 3);
    do_fetch(1, 3);
    check("R10 bound new", int'(next_pc_o), 555);
    // R7 write to another page leaves active page alone
    sw_write(1, 4, 999);
    do_fetch(1, 4);
    check("R7 isolate", int'(next_pc_o), bval(2, 4));
    sw_read(3, 4);
    check("R7 other page", int'(sw_rdata_o), bval(3, 4));
    idle(); tick();
    check("R8 rvalid low", int'(sw_rvalid_o), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule